// File: doc/BRIEF.md
# Keypad Controller Byte-Command Decoder

This block decodes the byte stream that a serial slave front end (for instance an I2C target) delivers to a keypad and GPIO controller. Each bus transaction begins with a start pulse. The first byte written after a start is taken as a command code. Every later written byte is a parameter, numbered from zero. Read bytes are produced for the command that is currently latched, numbered by their position since the start. A host therefore writes a command, then either appends its parameters in the same transaction or issues a repeated start and reads the response.

The block owns the controller's configuration, active time, debounce, keypad size and clock settings, and the three 16-bit GPIO registers (pull, direction, mask). It also keeps an interrupt status byte, a sticky error byte and an active-low interrupt line. Once a write command has taken all of its parameters, the latched command becomes an idle marker (0xFF), so a surplus parameter is reported as a bad parameter. Parameters are checked per command. Values that fail the check are stored anyway and raise an error. Writing the configuration empties the status byte and pulses a flush request toward the event queue. The event queue and the script engine sit outside this block.

Top module: `kpd_cmd_ctrl`

## Requirements
- R1: After hardware reset the settings are config 0x80, active time 125, debounce 3, keypad size 0x33 and clock 0x08. The GPIO registers and the error byte are zero, and the status byte is 0x10 (bit 4 = not initialised).
- R2: A start pulse sets the byte position to 0. A written byte at position 0 becomes the command. A written byte at position n>0 is parameter n−1. Each read returns the byte for the current position and then advances the position.
- R3: `irq_n` is low exactly when the status byte is nonzero.
- R4: Reading status (0x82) returns the status byte at position 0 and 0x00 at later positions. The read empties the status byte unless bit 4 is set, in which case the status byte is left unchanged.
- R5: A parameter sent to a command that takes none (including read commands), or a read of a command that has no response, sets error bit 1 (unknown command) and status bit 3. Codes 0x95–0x97 accept parameters with no effect.
- R6: Config (0x81), active time (0x8B), debounce (0x8F), keypad size (0x90) and clock (0x93) store parameter 0 and then latch 0xFF. A parameter arriving while 0xFF is latched stores nothing and sets error bit 0 (bad parameter) and status bit 3.
- R7: Pull (0x84), direction (0x85) and mask (0x86) load parameter 0 as the low byte with the high byte cleared. They OR parameter 1 into the high byte and then latch 0xFF.
- R8: Reset command 0x83 with parameter 0xAA restores every R1 value, including a zero error byte and zero GPIO registers. Any other parameter sets error bit 0 and changes nothing else.
- R9: A debounce of 0, a keypad size whose low nibble lies outside 3..12 or whose high nibble lies outside 3..8, or a clock byte whose bits [1:0] are 01 or 10, sets error bit 0. The value is still stored.
- R10: A config write clears the whole status byte. `evq_flush` is high for exactly the one cycle after the write.
- R11: Read responses: 0x80 gives 0x00, 0x04, then 0x00. 0x92 gives config & 0x0F. 0x94 gives (clock & 0xFC) | 0x02. 0x87 and 0x88 give the low byte, the high byte, then 0x00. 0x8C and 0x91 give the stored byte. 0x8E, 0x89 and 0x8A give 0x00.
- R12: Error bits are sticky. Only a hardware reset or an accepted reset command clears them, and reading them leaves them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_start | input | 1 | Start or repeated start seen by the front end |
| wr_valid | input | 1 | Byte on `wr_data` was written by the host this cycle |
| wr_data | input | 8 | Written byte |
| rd_req | input | 1 | Host reads one byte this cycle |
| rd_data | output | 8 | Response byte, valid while `rd_req` is high |
| irq_n | output | 1 | Active-low interrupt, low while status is nonzero |
| evq_flush | output | 1 | One-cycle flush request to the event queue |
| cfg_o | output | 8 | Configuration byte |
| active_o | output | 8 | Active time |
| debounce_o | output | 8 | Debounce time |
| kp_size_o | output | 8 | Keypad size (high nibble columns, low nibble rows) |
| clk_cfg_o | output | 8 | Clock configuration |
| gpio_pull_o | output | 16 | GPIO pull selection |
| gpio_dir_o | output | 16 | GPIO direction |
| gpio_mask_o | output | 16 | GPIO mask |

## Verification
The assertions assume that the front end raises at most one of `bus_start`, `wr_valid` and `rd_req` in any cycle, so that a byte is never counted in the same cycle as a start. They also assume that a read response is consumed in the same cycle that `rd_req` is high. The bench drives each event as a single-cycle pulse launched from the falling clock edge, with never more than one of the three strobes active at once. It always issues a start before a new command byte, and it sends surplus parameters and unknown codes only inside such well-formed transactions.

// File: rtl/kpd_cmd_pkg.sv
package kpd_cmd_pkg;

  localparam int BYTE_W = 8;
  localparam int GPIO_W = 16;

  localparam logic [BYTE_W-1:0] OP_ID_RD     = 8'h80;
  localparam logic [BYTE_W-1:0] OP_CFG_WR    = 8'h81;
  localparam logic [BYTE_W-1:0] OP_STAT_RD   = 8'h82;
  localparam logic [BYTE_W-1:0] OP_RESET     = 8'h83;
  localparam logic [BYTE_W-1:0] OP_PULL_WR   = 8'h84;
  localparam logic [BYTE_W-1:0] OP_DIR_WR    = 8'h85;
  localparam logic [BYTE_W-1:0] OP_MASK_WR   = 8'h86;
  localparam logic [BYTE_W-1:0] OP_DIR_RD    = 8'h87;
  localparam logic [BYTE_W-1:0] OP_MASK_RD   = 8'h88;
  localparam logic [BYTE_W-1:0] OP_QPOP_RD   = 8'h89;
  localparam logic [BYTE_W-1:0] OP_QPEEK_RD  = 8'h8A;
  localparam logic [BYTE_W-1:0] OP_ACT_WR    = 8'h8B;
  localparam logic [BYTE_W-1:0] OP_ERR_RD    = 8'h8C;
  localparam logic [BYTE_W-1:0] OP_ROT_RD    = 8'h8E;
  localparam logic [BYTE_W-1:0] OP_DEB_WR    = 8'h8F;
  localparam logic [BYTE_W-1:0] OP_SIZE_WR   = 8'h90;
  localparam logic [BYTE_W-1:0] OP_SIZE_RD   = 8'h91;
  localparam logic [BYTE_W-1:0] OP_CFG_RD    = 8'h92;
  localparam logic [BYTE_W-1:0] OP_CLK_WR    = 8'h93;
  localparam logic [BYTE_W-1:0] OP_CLK_RD    = 8'h94;
  localparam logic [BYTE_W-1:0] OP_SCR_LOAD  = 8'h95;
  localparam logic [BYTE_W-1:0] OP_SCR_GO    = 8'h96;
  localparam logic [BYTE_W-1:0] OP_SCR_HALT  = 8'h97;
  localparam logic [BYTE_W-1:0] OP_IDLE      = 8'hFF;

  localparam logic [BYTE_W-1:0] RESET_KEY    = 8'hAA;
  localparam logic [GPIO_W-1:0] CHIP_ID      = 16'h0400;

  localparam int ST_ERR_BIT    = 3;
  localparam int ST_NOINIT_BIT = 4;
  localparam int ER_BADPAR_BIT = 0;
  localparam int ER_UNKCMD_BIT = 1;

  localparam int KP_DIM_MIN  = 3;
  localparam int KP_ROW_MAX  = 12;
  localparam int KP_COL_MAX  = 8;

  typedef struct packed {
    logic [BYTE_W-1:0] cfg;
    logic [BYTE_W-1:0] act;
    logic [BYTE_W-1:0] deb;
    logic [BYTE_W-1:0] size;
    logic [BYTE_W-1:0] clk;
    logic [BYTE_W-1:0] status;
    logic [BYTE_W-1:0] err;
    logic [GPIO_W-1:0] pull;
    logic [GPIO_W-1:0] dir;
    logic [GPIO_W-1:0] mask;
  } kregs_t;

  function automatic kregs_t kregs_init();
    kregs_t r;
    r.cfg    = 8'h80;
    r.act    = 8'd125;
    r.deb    = 8'd3;
    r.size   = 8'h33;
    r.clk    = 8'h08;
    r.status = 8'h10;
    r.err    = '0;
    r.pull   = '0;
    r.dir    = '0;
    r.mask   = '0;
    return r;
  endfunction

  function automatic logic size_bad(input logic [BYTE_W-1:0] v);
    int unsigned lo;
    int unsigned hi;
    lo = int'(v[3:0]);
    hi = int'(v[7:4]);
    return (lo < KP_DIM_MIN) || (lo > KP_ROW_MAX) ||
           (hi < KP_DIM_MIN) || (hi > KP_COL_MAX);
  endfunction

  function automatic logic clk_bad(input logic [BYTE_W-1:0] v);
    return v[0] ^ v[1];
  endfunction

endpackage

// File: rtl/kpd_byte_seq.sv
module kpd_byte_seq #(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_start,
  input  logic             wr_valid,
  input  logic             rd_req,
  output logic             cmd_strobe,
  output logic             par_strobe,
  output logic             rd_strobe,
  output logic [IDX_W-1:0] par_idx,
  output logic [IDX_W-1:0] rd_idx
);

  localparam logic [IDX_W-1:0] IDX_MAX = {IDX_W{1'b1}};

  logic [IDX_W-1:0] pos_q;
  logic [IDX_W-1:0] pos_d;
  logic             pos_en;

  always_comb begin
    pos_en = bus_start | wr_valid | rd_req;
    if (bus_start)              pos_d = '0;
    else if (pos_q == IDX_MAX)  pos_d = pos_q;
    else                        pos_d = pos_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pos_q <= '0;
    else if (pos_en) pos_q <= pos_d;
  end

  assign cmd_strobe = wr_valid & ~bus_start & (pos_q == '0);
  assign par_strobe = wr_valid & ~bus_start & (pos_q != '0);
  assign rd_strobe  = rd_req & ~bus_start & ~wr_valid;
  assign par_idx    = pos_q - 1'b1;
  assign rd_idx     = pos_q;

  // R2: a start always leaves the position at zero
  assert_start_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_start |=> (rd_idx == '0));

  // R2: a read moves the position forward unless saturated
  assert_read_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && rd_idx != IDX_MAX) |=> (rd_idx == $past(rd_idx) + 1'b1));

endmodule

// File: rtl/kpd_rd_mux.sv
module kpd_rd_mux
  import kpd_cmd_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic [BYTE_W-1:0] cmd,
  input  logic [IDX_W-1:0]  idx,
  input  kregs_t            regs,
  output logic [BYTE_W-1:0] rd_byte,
  output logic              rd_known
);

  function automatic logic [BYTE_W-1:0] pick16(input logic [GPIO_W-1:0] w,
                                               input logic [IDX_W-1:0] i);
    if (i == '0)                        return w[BYTE_W-1:0];
    else if (i == {{(IDX_W-1){1'b0}}, 1'b1}) return w[GPIO_W-1:BYTE_W];
    else                                return '0;
  endfunction

  always_comb begin
    rd_byte  = '0;
    rd_known = 1'b1;
    unique case (cmd)
      OP_ID_RD:    rd_byte = pick16(CHIP_ID, idx);
      OP_STAT_RD:  rd_byte = (idx == '0) ? regs.status : '0;
      OP_DIR_RD:   rd_byte = pick16(regs.dir, idx);
      OP_MASK_RD:  rd_byte = pick16(regs.mask, idx);
      OP_QPOP_RD,
      OP_QPEEK_RD,
      OP_ROT_RD:   rd_byte = '0;
      OP_ERR_RD:   rd_byte = regs.err;
      OP_SIZE_RD:  rd_byte = regs.size;
      OP_CFG_RD:   rd_byte = {4'h0, regs.cfg[3:0]};
      OP_CLK_RD:   rd_byte = {regs.clk[7:2], 2'b10};
      default:     rd_known = 1'b0;
    endcase
  end

endmodule

// File: rtl/kpd_reg_file.sv
module kpd_reg_file
  import kpd_cmd_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_strobe,
  input  logic              par_strobe,
  input  logic              rd_strobe,
  input  logic [IDX_W-1:0]  par_idx,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              rd_known,
  output logic [BYTE_W-1:0] cmd_q,
  output kregs_t            regs_q,
  output logic              flush_q
);

  kregs_t            regs_d;
  logic [BYTE_W-1:0] cmd_d;
  logic              flush_d;
  logic              bad_par;
  logic              bad_cmd;
  logic              upd_en;

  always_comb begin
    regs_d  = regs_q;
    cmd_d   = cmd_q;
    flush_d = 1'b0;
    bad_par = 1'b0;
    bad_cmd = 1'b0;

    if (cmd_strobe) begin
      cmd_d = wdata;
    end else if (par_strobe) begin
      case (cmd_q)
        OP_CFG_WR: begin
          regs_d.cfg    = wdata;
          regs_d.status = '0;
          flush_d       = 1'b1;
          cmd_d         = OP_IDLE;
        end
        OP_RESET: begin
          if (wdata == RESET_KEY) regs_d = kregs_init();
          else                    bad_par = 1'b1;
          cmd_d = OP_IDLE;
        end
        OP_PULL_WR: begin
          if (par_idx == '0) regs_d.pull = {{(GPIO_W-BYTE_W){1'b0}}, wdata};
          else begin
            regs_d.pull[GPIO_W-1:BYTE_W] = regs_q.pull[GPIO_W-1:BYTE_W] | wdata;
            cmd_d = OP_IDLE;
          end
        end
        OP_DIR_WR: begin
          if (par_idx == '0) regs_d.dir = {{(GPIO_W-BYTE_W){1'b0}}, wdata};
          else begin
            regs_d.dir[GPIO_W-1:BYTE_W] = regs_q.dir[GPIO_W-1:BYTE_W] | wdata;
            cmd_d = OP_IDLE;
          end
        end
        OP_MASK_WR: begin
          if (par_idx == '0) regs_d.mask = {{(GPIO_W-BYTE_W){1'b0}}, wdata};
          else begin
            regs_d.mask[GPIO_W-1:BYTE_W] = regs_q.mask[GPIO_W-1:BYTE_W] | wdata;
            cmd_d = OP_IDLE;
          end
        end
        OP_ACT_WR: begin
          regs_d.act = wdata;
          cmd_d      = OP_IDLE;
        end
        OP_DEB_WR: begin
          regs_d.deb = wdata;
          bad_par    = (wdata == '0);
          cmd_d      = OP_IDLE;
        end
        OP_SIZE_WR: begin
          regs_d.size = wdata;
          bad_par     = size_bad(wdata);
          cmd_d       = OP_IDLE;
        end
        OP_CLK_WR: begin
          regs_d.clk = wdata;
          bad_par    = clk_bad(wdata);
          cmd_d      = OP_IDLE;
        end
        OP_SCR_LOAD, OP_SCR_GO, OP_SCR_HALT: begin
        end
        OP_IDLE: bad_par = 1'b1;
        default: bad_cmd = 1'b1;
      endcase
    end else if (rd_strobe) begin
      if (!rd_known) bad_cmd = 1'b1;
      else if (cmd_q == OP_STAT_RD && !regs_q.status[ST_NOINIT_BIT])
        regs_d.status = '0;
    end

    if (bad_par) regs_d.err[ER_BADPAR_BIT] = 1'b1;
    if (bad_cmd) regs_d.err[ER_UNKCMD_BIT] = 1'b1;
    if (bad_par || bad_cmd) regs_d.status[ST_ERR_BIT] = 1'b1;
  end

  assign upd_en = cmd_strobe | par_strobe | rd_strobe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs_q <= kregs_init();
      cmd_q  <= OP_IDLE;
    end else if (upd_en) begin
      regs_q <= regs_d;
      cmd_q  <= cmd_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flush_q <= 1'b0;
    else        flush_q <= flush_d;
  end

  // R6: surplus parameter flags a bad parameter
  assert_idle_badpar_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (par_strobe && cmd_q == OP_IDLE) |=>
      (regs_q.err[ER_BADPAR_BIT] && regs_q.status[ST_ERR_BIT]));

  // R6: single-parameter writes fall back to the idle marker
  assert_single_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (par_strobe && (cmd_q == OP_ACT_WR || cmd_q == OP_DEB_WR ||
                    cmd_q == OP_SIZE_WR || cmd_q == OP_CLK_WR)) |=>
      (cmd_q == OP_IDLE));

  // R5: reading a code with no response raises unknown command
  assert_unknown_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !rd_known) |=>
      (regs_q.err[ER_UNKCMD_BIT] && regs_q.status[ST_ERR_BIT]));

  // R4: the not-initialised flag survives a status read
  assert_noinit_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && cmd_q == OP_STAT_RD && regs_q.status[ST_NOINIT_BIT]) |=>
      $stable(regs_q.status));

  // R10: config write empties status and requests a flush
  assert_cfg_flush_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (par_strobe && cmd_q == OP_CFG_WR) |=> (flush_q && regs_q.status == '0));

  // R12: error bits only drop after an accepted reset command
  assert_err_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(regs_q.err[ER_BADPAR_BIT]) || $fell(regs_q.err[ER_UNKCMD_BIT])) |->
      $past(par_strobe && cmd_q == OP_RESET && wdata == RESET_KEY));

endmodule

// File: rtl/kpd_cmd_ctrl.sv
module kpd_cmd_ctrl
  import kpd_cmd_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_start,
  input  logic              wr_valid,
  input  logic [7:0]        wr_data,
  input  logic              rd_req,
  output logic [7:0]        rd_data,
  output logic              irq_n,
  output logic              evq_flush,
  output logic [7:0]        cfg_o,
  output logic [7:0]        active_o,
  output logic [7:0]        debounce_o,
  output logic [7:0]        kp_size_o,
  output logic [7:0]        clk_cfg_o,
  output logic [15:0]       gpio_pull_o,
  output logic [15:0]       gpio_dir_o,
  output logic [15:0]       gpio_mask_o
);

  logic              cmd_strobe;
  logic              par_strobe;
  logic              rd_strobe;
  logic [IDX_W-1:0]  par_idx;
  logic [IDX_W-1:0]  rd_idx;
  logic [BYTE_W-1:0] cmd_q;
  logic              rd_known;
  kregs_t            regs_q;

  kpd_byte_seq #(.IDX_W(IDX_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_start  (bus_start),
    .wr_valid   (wr_valid),
    .rd_req     (rd_req),
    .cmd_strobe (cmd_strobe),
    .par_strobe (par_strobe),
    .rd_strobe  (rd_strobe),
    .par_idx    (par_idx),
    .rd_idx     (rd_idx)
  );

  kpd_rd_mux #(.IDX_W(IDX_W)) u_mux (
    .cmd      (cmd_q),
    .idx      (rd_idx),
    .regs     (regs_q),
    .rd_byte  (rd_data),
    .rd_known (rd_known)
  );

  kpd_reg_file #(.IDX_W(IDX_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_strobe (cmd_strobe),
    .par_strobe (par_strobe),
    .rd_strobe  (rd_strobe),
    .par_idx    (par_idx),
    .wdata      (wr_data),
    .rd_known   (rd_known),
    .cmd_q      (cmd_q),
    .regs_q     (regs_q),
    .flush_q    (evq_flush)
  );

  assign irq_n       = (regs_q.status == '0);
  assign cfg_o       = regs_q.cfg;
  assign active_o    = regs_q.act;
  assign debounce_o  = regs_q.deb;
  assign kp_size_o   = regs_q.size;
  assign clk_cfg_o   = regs_q.clk;
  assign gpio_pull_o = regs_q.pull;
  assign gpio_dir_o  = regs_q.dir;
  assign gpio_mask_o = regs_q.mask;

  // R3: interrupt releases only after a bus byte that can empty status
  assert_irq_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_n) |-> $past(rd_strobe || par_strobe));

  // R10: a flush request never lasts more than one cycle
  assert_flush_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    evq_flush |=> !evq_flush);

endmodule

// File: tb/kpd_cmd_ctrl_tb_top.sv
module kpd_cmd_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_start = 1'b0;
  logic        wr_valid = 1'b0;
  logic [7:0]  wr_data = '0;
  logic        rd_req = 1'b0;
  logic [7:0]  rd_data;
  logic        irq_n;
  logic        evq_flush;
  logic [7:0]  cfg_o, active_o, debounce_o, kp_size_o, clk_cfg_o;
  logic [15:0] gpio_pull_o, gpio_dir_o, gpio_mask_o;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } sb_item_t;
  sb_item_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  kpd_cmd_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .wr_valid(wr_valid),
    .wr_data(wr_data), .rd_req(rd_req), .rd_data(rd_data), .irq_n(irq_n),
    .evq_flush(evq_flush), .cfg_o(cfg_o), .active_o(active_o),
    .debounce_o(debounce_o), .kp_size_o(kp_size_o), .clk_cfg_o(clk_cfg_o),
    .gpio_pull_o(gpio_pull_o), .gpio_dir_o(gpio_dir_o), .gpio_mask_o(gpio_mask_o)
  );

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard while a read byte is presented
  always @(negedge clk) begin
    #(CLK_PERIOD/4);
    if (rd_req) begin
      checks++;
      if (sb_q.size() == 0) begin
        failures++;
        $display("FAIL R2 unexpected read actual=%h expected=none", rd_data);
      end else begin
        sb_item_t it;
        it = sb_q.pop_front();
        if (rd_data !== it.exp) begin
          failures++;
          $display("FAIL %s read actual=%h expected=%h", it.tag, rd_data, it.exp);
        end
      end
    end
  end

  task automatic start_t();
    @(negedge clk); bus_start = 1'b1;
    @(negedge clk); bus_start = 1'b0;
  endtask

  task automatic wbyte(input logic [7:0] v);
    @(negedge clk); wr_valid = 1'b1; wr_data = v;
    @(negedge clk); wr_valid = 1'b0;
  endtask

  task automatic rbyte(input logic [7:0] exp, input string tag);
    sb_item_t it;
    it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk); rd_req = 1'b1;
    @(negedge clk); rd_req = 1'b0;
  endtask

  task automatic cmd1(input logic [7:0] c, input logic [7:0] p);
    start_t(); wbyte(c); wbyte(p);
  endtask

  task automatic read1(input logic [7:0] c, input logic [7:0] exp, input string tag);
    start_t(); wbyte(c); start_t(); rbyte(exp, tag);
  endtask

  task automatic soft_reset();
    cmd1(8'h83, 8'hAA);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(cfg_o, 16'h80, "R1 cfg");
    chk(active_o, 16'd125, "R1 active");
    chk(debounce_o, 16'd3, "R1 debounce");
    chk(kp_size_o, 16'h33, "R1 size");
    chk(clk_cfg_o, 16'h08, "R1 clock");
    chk(gpio_dir_o, 16'h0000, "R1 gpio");
    chk(evq_flush, 16'h0, "R1 flush");
    chk(irq_n, 16'h0, "R3 irq low at reset");
    // R4 status read keeps not-initialised flag; R2 byte position
    read1(8'h82, 8'h10, "R4 status");
    rbyte(8'h00, "R4 status byte1");
    chk(irq_n, 16'h0, "R4 noinit kept");
    // R11 id, R2 position
    start_t(); wbyte(8'h80); start_t();
    rbyte(8'h00, "R11 id b0"); rbyte(8'h04, "R2 id b1"); rbyte(8'h00, "R11 id b2");
    // R10 config write
    start_t(); wbyte(8'h81); wbyte(8'h05);
    chk(evq_flush, 16'h1, "R10 flush high");
    chk(cfg_o, 16'h05, "R6 cfg stored");
    chk(irq_n, 16'h1, "R3 irq released");
    wbyte(8'h77);
    chk(evq_flush, 16'h0, "R10 flush one cycle");
    // R6 surplus parameter
    chk(irq_n, 16'h0, "R6 surplus irq");
    chk(cfg_o, 16'h05, "R6 surplus not stored");
    read1(8'h8C, 8'h01, "R6 badpar bit");
    read1(8'h92, 8'h05, "R11 cfg read");
    read1(8'h82, 8'h08, "R4 status err");
    chk(irq_n, 16'h1, "R4 status cleared");
    read1(8'h82, 8'h00, "R4 status empty");
    // R5 unknown write
    cmd1(8'h70, 8'h12);
    read1(8'h8C, 8'h03, "R5 unknown write");
    chk(irq_n, 16'h0, "R5 status err");
    // R8 bad reset key
    cmd1(8'h83, 8'h55);
    chk(cfg_o, 16'h05, "R8 bad key no reset");
    read1(8'h8C, 8'h03, "R12 sticky");
    soft_reset();
    chk(cfg_o, 16'h80, "R8 cfg restored");
    read1(8'h8C, 8'h00, "R8 err cleared");
    // R5 unknown read
    read1(8'h81, 8'h00, "R5 unknown read data");
    read1(8'h8C, 8'h02, "R5 unknown read bit");
    read1(8'h82, 8'h18, "R4 noinit read1");
    read1(8'h82, 8'h18, "R4 noinit read2");
    soft_reset();
    // R7 gpio
    start_t(); wbyte(8'h85); wbyte(8'h34); wbyte(8'h12);
    chk(gpio_dir_o, 16'h1234, "R7 dir");
    start_t(); wbyte(8'h87); start_t();
    rbyte(8'h34, "R11 dir lo"); rbyte(8'h12, "R11 dir hi"); rbyte(8'h00, "R11 dir b2");
    start_t(); wbyte(8'h86); wbyte(8'hCD); wbyte(8'hAB);
    start_t(); wbyte(8'h88); start_t();
    rbyte(8'hCD, "R11 mask lo"); rbyte(8'hAB, "R11 mask hi");
    chk(gpio_mask_o, 16'hABCD, "R7 mask");
    start_t(); wbyte(8'h84); wbyte(8'h0F); wbyte(8'hF0); wbyte(8'h11);
    chk(gpio_pull_o, 16'hF00F, "R7 pull");
    read1(8'h8C, 8'h01, "R6 gpio surplus");
    start_t(); wbyte(8'h85); wbyte(8'h56);
    chk(gpio_dir_o, 16'h0056, "R7 low byte clears high");
    soft_reset();
    chk(gpio_dir_o, 16'h0000, "R8 gpio restored");
    // R9 validation
    cmd1(8'h8F, 8'h00);
    chk(debounce_o, 16'h00, "R9 debounce stored");
    read1(8'h8C, 8'h01, "R9 debounce zero");
    soft_reset();
    cmd1(8'h90, 8'h93);
    read1(8'h91, 8'h93, "R9 size stored");
    read1(8'h8C, 8'h01, "R9 size cols high");
    soft_reset();
    cmd1(8'h90, 8'h8C);
    read1(8'h8C, 8'h00, "R9 size edge ok");
    cmd1(8'h90, 8'h32);
    read1(8'h8C, 8'h01, "R9 size rows low");
    soft_reset();
    cmd1(8'h93, 8'h01);
    read1(8'h94, 8'h02, "R11 clock read");
    read1(8'h8C, 8'h01, "R9 clock 01");
    soft_reset();
    cmd1(8'h93, 8'hF7);
    read1(8'h94, 8'hF6, "R11 clock read 2");
    read1(8'h8C, 8'h00, "R9 clock 11 ok");
    cmd1(8'h93, 8'h02);
    read1(8'h8C, 8'h01, "R9 clock 10");
    // R6 active, R11 rotator
    cmd1(8'h8B, 8'h40);
    chk(active_o, 16'h40, "R6 active stored");
    read1(8'h8E, 8'h00, "R11 rotator");
    repeat (2) @(negedge clk);
    chk(sb_q.size(), 16'h0, "R2 all reads seen");
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule